// File: doc/BRIEF.md
# DMA Chained Descriptor Sequencer

This block is the control sequencer of a DMA engine. A trigger request carries a source index. The sequencer uses that index to read one vector word, which names the first control-record slot. It then loads that record and moves the record's block of data one word at a time. It writes the changed fields of the record back to memory. If the record's chain bit is set, it goes on to the record in the next slot and repeats the same steps. Triggers that arrive while a chain is running wait in a small in-order queue.

Every memory access goes through one master port. The memory answers a read in the same cycle and performs a write at the clock edge. Only the first record of a chain decides the completion side-effects. When that record's count reaches zero, the block emits a one-cycle enable-clear strobe, which carries the source index, and a one-cycle interrupt pulse.

Top module: `dma_chain_seq`

## Requirements
- R1: After reset, busy, irq, en_clr and mem_req are all 0.
- R2: A trigger with index i reads the vector word at VEC_BASE+i, and bits [4:0] of that word give the first slot s. The record of slot s occupies six consecutive words at CTRL_BASE+6*s: control word (+0), block size (+1), count (+2), reload (+3), source address (+4) and destination address (+5).
- R3: For a block size of N, the record's data move reads the word at src+k and writes it to dst+k, for k from 0 to N-1 in ascending order. A block size of 0 moves nothing.
- R4: After its move, each record has three words written back, in this order: count (+2), the advanced source address src+N (+4) and the advanced destination address dst+N (+5). All three writes finish before any access that belongs to the next record.
- R5: When bit 0 of the control word is 1, the chain continues with slot s+1. When it is 0, the chain ends after that record's write-back.
- R6: Slot 23 always ends the chain, whatever its chain bit holds.
- R7: The first record's count is written back decremented by one. Records reached through the chain have their count written back unchanged.
- R8: When the first record's decremented count is 0, en_clr (with en_clr_src equal to the trigger index) and irq are each high for exactly one cycle. That cycle is the one after the chain's final write-back. Otherwise neither goes high. The counts of later records never cause either signal.
- R9: busy goes high in the cycle after a trigger is accepted. It stays high until the final write-back. With no trigger pending, it is low in the next cycle. For one trigger, busy lasts 2 + Σ(9 + 2·N) cycles, summed over the records of the chain.
- R10: Triggers that arrive while the block is busy are queued, up to QDEPTH of them. They are served in the order they arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_valid | input | 1 | Trigger request strobe |
| trig_src | input | 5 | Source index of the trigger |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the same cycle as the read |
| busy | output | 1 | Trigger accepted or chain in progress |
| en_clr | output | 1 | One-cycle strobe that clears the trigger's enable |
| en_clr_src | output | 5 | Index whose enable is cleared |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
The assertions assume three things about the environment. First, the trigger queue never receives a request while it is full. Second, every vector word names a slot below 24. Third, memory returns read data in the same cycle as the request. The stimulus respects these limits. It issues at most three back-to-back triggers against a queue of four. It writes only slots 0 to 23 into the vector table. Its memory model reads combinationally and writes on the edge. It also keeps the data, record and vector regions separate, so no move overwrites a record.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 32;
  localparam int REC_WORDS = 6;
  localparam int OFF_CNT   = 2;
  localparam int OFF_SRC   = 4;
  localparam int OFF_DST   = 5;

  typedef enum logic [2:0] {ST_IDLE, ST_VEC, ST_LD, ST_MRD, ST_MWR, ST_WB} seq_st_e;

  // first word of a record slot
  function automatic logic [ADDR_W-1:0] slot_base(input logic [ADDR_W-1:0] area,
                                                 input logic [4:0] slot);
    return area + ADDR_W'(slot) * ADDR_W'(REC_WORDS);
  endfunction

  // count value that is written back
  function automatic logic [DATA_W-1:0] count_after(input logic [DATA_W-1:0] c,
                                                    input logic head);
    return head ? c - DATA_W'(1) : c;
  endfunction
endpackage

// File: rtl/dcs_pending_fifo.sv
module dcs_pending_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slots [DEPTH];
  logic [PW-1:0] rd_p, wr_p;
  logic [CW-1:0] fill;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  wire do_push = push && !full;
  wire do_pop  = pop && !empty;

  assign empty = (fill == '0);
  assign full  = (fill == CW'(DEPTH));
  assign dout  = slots[rd_p];

  always_ff @(posedge clk) begin
    if (do_push) slots[wr_p] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_p <= '0;
      wr_p <= '0;
      fill <= '0;
    end else begin
      if (do_push) wr_p <= step(wr_p);
      if (do_pop)  rd_p <= step(rd_p);
      fill <= fill + CW'(do_push) - CW'(do_pop);
    end
  end

  // R10: requests never arrive while the queue is full
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
  // R10: a pop always leaves one entry fewer when nothing is pushed
  a_r10_pop_drains: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pop && !push) |=> (fill == $past(fill) - CW'(1)));
endmodule

// File: rtl/dcs_engine.sv
module dcs_engine
  import dcs_pkg::*;
#(
  parameter int                NSLOT     = 24,
  parameter int                SRC_W     = 5,
  parameter logic [ADDR_W-1:0] VEC_BASE  = 16'h0000,
  parameter logic [ADDR_W-1:0] CTRL_BASE = 16'h0040
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_empty,
  input  logic [SRC_W-1:0]  q_dout,
  output logic              q_pop,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              active,
  output logic              en_clr,
  output logic [SRC_W-1:0]  en_clr_src,
  output logic              irq
);
  localparam logic [4:0] LAST_SLOT = 5'(NSLOT - 1);

  seq_st_e          st;
  logic [2:0]       widx;
  logic [SRC_W-1:0] src_id;
  logic [4:0]       slot;
  logic             chain_bit, head, zero_hit;
  logic [DATA_W-1:0] blk, cnt, sa, da, units, hold;

  // named events
  logic [ADDR_W-1:0] base;
  logic [DATA_W-1:0] cnt_wb;
  logic wb_last, chain_go, seq_end;

  assign base     = slot_base(CTRL_BASE, slot);
  assign cnt_wb   = count_after(cnt, head);
  assign wb_last  = (st == ST_WB) && (widx == 3'd2);
  assign chain_go = wb_last && chain_bit && (slot != LAST_SLOT);
  assign seq_end  = wb_last && !chain_go;
  assign q_pop    = (st == ST_IDLE) && !q_empty;
  assign active   = (st != ST_IDLE);

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (st)
      ST_VEC: begin mem_req = 1'b1; mem_addr = VEC_BASE + ADDR_W'(src_id); end
      ST_LD:  begin mem_req = 1'b1; mem_addr = base + ADDR_W'(widx); end
      ST_MRD: begin mem_req = 1'b1; mem_addr = sa[ADDR_W-1:0]; end
      ST_MWR: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = da[ADDR_W-1:0]; mem_wdata = hold;
      end
      ST_WB: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        case (widx)
          3'd0:    begin mem_addr = base + ADDR_W'(OFF_CNT); mem_wdata = cnt_wb; end
          3'd1:    begin mem_addr = base + ADDR_W'(OFF_SRC); mem_wdata = sa; end
          default: begin mem_addr = base + ADDR_W'(OFF_DST); mem_wdata = da; end
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; widx <= '0; src_id <= '0; slot <= '0;
      chain_bit <= 1'b0; head <= 1'b0; zero_hit <= 1'b0;
      blk <= '0; cnt <= '0; sa <= '0; da <= '0; units <= '0; hold <= '0;
      en_clr <= 1'b0; en_clr_src <= '0; irq <= 1'b0;
    end else begin
      en_clr <= 1'b0;
      irq    <= 1'b0;
      unique case (st)
        ST_IDLE: if (!q_empty) begin
          src_id <= q_dout; head <= 1'b1; zero_hit <= 1'b0; st <= ST_VEC;
        end
        ST_VEC: begin
          slot <= mem_rdata[4:0]; widx <= '0; st <= ST_LD;
        end
        ST_LD: begin
          case (widx)
            3'd0: chain_bit <= mem_rdata[0];
            3'd1: blk <= mem_rdata;
            3'd2: cnt <= mem_rdata;
            3'd4: sa  <= mem_rdata;
            3'd5: da  <= mem_rdata;
            default: ;
          endcase
          if (widx == 3'd5) begin
            widx  <= '0;
            units <= blk;
            st    <= (blk == '0) ? ST_WB : ST_MRD;
          end else begin
            widx <= widx + 3'd1;
          end
        end
        ST_MRD: begin hold <= mem_rdata; st <= ST_MWR; end
        ST_MWR: begin
          sa <= sa + DATA_W'(1);
          da <= da + DATA_W'(1);
          units <= units - DATA_W'(1);
          st <= (units == DATA_W'(1)) ? ST_WB : ST_MRD;
        end
        ST_WB: begin
          if (widx == 3'd0 && head) zero_hit <= (cnt_wb == '0);
          if (!wb_last) begin
            widx <= widx + 3'd1;
          end else begin
            widx <= '0;
            if (chain_go) begin
              slot <= slot + 5'd1; head <= 1'b0; st <= ST_LD;
            end else begin
              st <= ST_IDLE;
              irq <= zero_hit;
              en_clr <= zero_hit;
              en_clr_src <= src_id;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R8: completion pulse is a single cycle
  a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq);
  // R8: completion follows the final write-back
  a_r8_irq_after_end: assert property (@(posedge clk) disable iff (!rst_n) irq |-> $past(seq_end));
  // R8: enable clear and interrupt always coincide
  a_r8_clr_with_irq: assert property (@(posedge clk) disable iff (!rst_n) irq == en_clr);
  // R4: a chained record is loaded only right after a full write-back
  a_r4_wb_before_next: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LD && widx == 3'd0 && !head) |-> $past(wb_last));
  // R6: the last slot ends the chain
  a_r6_last_slot_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_last && slot == LAST_SLOT) |=> (st == ST_IDLE));
  // R3: every data write is preceded by its data read
  a_r3_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MWR) |-> $past(st == ST_MRD));
endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
  import dcs_pkg::*;
#(
  parameter int                NSLOT     = 24,
  parameter int                NSRC      = 24,
  parameter int                QDEPTH    = 4,
  parameter logic [ADDR_W-1:0] VEC_BASE  = 16'h0000,
  parameter logic [ADDR_W-1:0] CTRL_BASE = 16'h0040,
  localparam int               SRC_W     = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_valid,
  input  logic [SRC_W-1:0]  trig_src,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              en_clr,
  output logic [SRC_W-1:0]  en_clr_src,
  output logic              irq
);
  logic             q_empty, q_full, q_pop, eng_active;
  logic [SRC_W-1:0] q_dout;

  dcs_pending_fifo #(.DEPTH(QDEPTH), .W(SRC_W)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(trig_valid), .din(trig_src),
    .pop(q_pop), .dout(q_dout), .empty(q_empty), .full(q_full)
  );

  dcs_engine #(.NSLOT(NSLOT), .SRC_W(SRC_W), .VEC_BASE(VEC_BASE), .CTRL_BASE(CTRL_BASE)) u_eng (
    .clk(clk), .rst_n(rst_n), .q_empty(q_empty), .q_dout(q_dout), .q_pop(q_pop),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .active(eng_active), .en_clr(en_clr),
    .en_clr_src(en_clr_src), .irq(irq)
  );

  assign busy = eng_active || !q_empty;

  // R9: an accepted trigger makes the block busy in the next cycle
  a_r9_busy_after_trig: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_valid && !q_full) |=> busy);
  // R1: memory is idle whenever the block is not busy
  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);
endmodule

// File: tb/sim_dma_chain_seq.sv
module sim_dma_chain_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig_valid = 1'b0;
  logic [4:0]  trig_src = '0;
  logic        mem_req, mem_we, busy, en_clr, irq;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [4:0]  en_clr_src;

  always #4 clk = ~clk;

  dma_chain_seq u0 (
    .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_src(trig_src),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .en_clr(en_clr), .en_clr_src(en_clr_src), .irq(irq)
  );

  logic [31:0] mem [0:511];
  logic [31:0] sh  [0:511];
  assign mem_rdata = mem[mem_addr[8:0]];
  always @(posedge clk) if (mem_req && mem_we) mem[mem_addr[8:0]] <= mem_wdata;

  int total = 0, bad = 0;
  logic [47:0] wq[$];
  string       wtag[$];
  logic [4:0]  iq[$];
  int          exp_busy;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic put(input int a, input logic [31:0] d, input string t);
    wq.push_back({16'(a), d});
    wtag.push_back(t);
    sh[a] = d;
  endtask

  // expected write stream of one trigger, derived from the requirements
  task automatic exp_run(input int idx, input string tx);
    int s, b, n, sa, da;
    bit head, zero;
    logic [31:0] nc;
    s = int'(sh[idx][4:0]); head = 1; zero = 0; exp_busy = 2;
    forever begin
      b = 'h40 + 6 * s;
      n = int'(sh[b + 1]); sa = int'(sh[b + 4]); da = int'(sh[b + 5]);
      for (int k = 0; k < n; k++) put(da + k, sh[sa + k], {"R3 move ", tx});
      nc = head ? sh[b + 2] - 1 : sh[b + 2];
      put(b + 2, nc, {"R7 count ", tx});
      put(b + 4, 32'(sa + n), {"R4 src ", tx});
      put(b + 5, 32'(da + n), {"R4 dst ", tx});
      exp_busy += 9 + 2 * n;
      if (head) zero = (nc == 0);
      if (sh[b][0] && s != 23) begin s++; head = 0; end
      else break;
    end
    if (zero) iq.push_back(5'(idx));
  endtask

  // monitor / scoreboard
  always @(negedge clk) if (rst_n) begin
    if (mem_req && mem_we) begin
      if (wq.size() == 0) chk(0, "R5/R6 unexpected write", {16'h0, mem_addr, mem_wdata}, 64'h0);
      else begin
        logic [47:0] e;
        string t;
        e = wq.pop_front();
        t = wtag.pop_front();
        chk({mem_addr, mem_wdata} == e, t, {16'h0, mem_addr, mem_wdata}, {16'h0, e});
      end
    end
    if (irq || en_clr) begin
      if (iq.size() == 0) chk(0, "R8 unexpected completion", {62'h0, irq, en_clr}, 64'h0);
      else begin
        logic [4:0] ei;
        ei = iq.pop_front();
        chk(irq && en_clr && en_clr_src == ei, "R8/R10 completion src",
            {57'h0, irq, en_clr, en_clr_src}, {57'h0, 2'b11, ei});
      end
    end
  end

  task automatic set_rec(input int s, input logic [31:0] c, input int n, input logic [31:0] cnt,
                         input int sa, input int da);
    int b;
    b = 'h40 + 6 * s;
    mem[b] = c; mem[b+1] = 32'(n); mem[b+2] = cnt; mem[b+3] = 32'h55;
    mem[b+4] = 32'(sa); mem[b+5] = 32'(da);
    for (int k = 0; k < 6; k++) sh[b+k] = mem[b+k];
  endtask

  task automatic set_vec(input int i, input int s);
    mem[i] = 32'hABCD_0000 | 32'(s); sh[i] = mem[i];
  endtask

  task automatic run_one(input int idx, input string tx);
    int cyc;
    @(negedge clk);
    trig_valid = 1'b1; trig_src = 5'(idx);
    exp_run(idx, tx);
    @(negedge clk);
    trig_valid = 1'b0;
    cyc = 0;
    while (busy) begin cyc++; @(negedge clk); end
    chk(cyc == exp_busy, {"R9 busy length ", tx}, 64'(cyc), 64'(exp_busy));
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int a = 0; a < 512; a++) begin mem[a] = 32'hA500_0000 + 32'(a * 37); sh[a] = mem[a]; end
    repeat (3) @(negedge clk);
    chk(!busy && !irq && !en_clr && !mem_req, "R1 reset outputs",
        {60'h0, busy, irq, en_clr, mem_req}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // single record, no chain, count stays nonzero
    set_vec(1, 0); set_rec(0, 32'h0, 3, 32'd5, 'h100, 'h180);
    run_one(1, "T-single R2");
    // three-record chain, head count hits zero, later counts untouched
    set_vec(2, 2);
    set_rec(2, 32'h1, 2, 32'd1, 'h110, 'h190);
    set_rec(3, 32'hF1, 1, 32'd1, 'h120, 'h1A0);
    set_rec(4, 32'hF0, 2, 32'd7, 'h128, 'h1A8);
    run_one(2, "T-chain R5");
    // slot 23 stops the chain although its chain bit is set
    set_vec(3, 22);
    set_rec(22, 32'h1, 1, 32'd9, 'h130, 'h1B0);
    set_rec(23, 32'h1, 1, 32'd2, 'h131, 'h1B1);
    run_one(3, "T-last R6");
    // empty block, head count 1 -> completion
    set_vec(4, 5); set_rec(5, 32'h0, 0, 32'd1, 'h140, 'h1C0);
    run_one(4, "T-empty R3");
    // repeat first pattern: count 4 -> 3, addresses continue
    run_one(1, "T-again R7");
    // queued triggers served in order
    set_vec(5, 6); set_rec(6, 32'h0, 1, 32'd1, 'h150, 'h1D0);
    set_vec(6, 7); set_rec(7, 32'h0, 2, 32'd2, 'h151, 'h1D4);
    set_vec(7, 8); set_rec(8, 32'h0, 1, 32'd1, 'h153, 'h1D8);
    @(negedge clk);
    trig_valid = 1'b1; trig_src = 5'd5; exp_run(5, "T-queue R10");
    @(negedge clk);
    chk(busy, "R9 busy after trigger", 64'(busy), 64'h1);
    trig_src = 5'd6; exp_run(6, "T-queue R10");
    @(negedge clk);
    trig_src = 5'd7; exp_run(7, "T-queue R10");
    @(negedge clk);
    trig_valid = 1'b0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);

    chk(wq.size() == 0, "R4 all writes seen", 64'(wq.size()), 64'h0);
    chk(iq.size() == 0, "R8 all completions seen", 64'(iq.size()), 64'h0);
    chk(mem['h1B2] == 32'hA500_0000 + 32'('h1B2 * 37), "R6 no record past slot 23",
        {32'h0, mem['h1B2]}, {32'h0, 32'hA500_0000 + 32'('h1B2 * 37)});
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=%h exp=%h", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule